// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Start Validation

This block turns an asynchronous serial line into parallel characters. A synchronizer brings the line into the system clock domain. While the receiver is idle it watches for a low level. In the oversampled modes it checks the line again half a bit time later, and it accepts the start bit only if the line is still low. Otherwise it treats the event as a glitch and goes back to idle. After a valid start it samples each data bit, the optional parity bit and the stop bit at the centre of the bit. The assembled character then moves from the shift register into a buffer register.

The host reads the buffer register through a one-cycle read strobe. The block presents a ready flag together with per-character status: parity error, framing error and break detect. An overrun flag stays set until the next read. A one-cycle `rx_tick` enable acts as the receive clock. Programmable fields select the oversampling ratio (1, 16 or 64 ticks per bit), the character length (5 to 8 bits) and the parity setting.

Top module: `async_rx_core`

## Requirements
- R1: After synchronous reset `rx_ready`, `par_err`, `frm_err`, `ovr_err`, `brk_det` are 0 and `rx_data` is 0.
- R2: With `div_sel` at 16x or 64x, a low pulse on `rxd` that is shorter than half a bit time is treated as a false start. No character is produced, and a following valid frame is received correctly.
- R3: Data bits arrive LSB first. The bit count is 5 + `len_sel` (00=5, 01=6, 10=7, 11=8). Unused upper bits of `rx_data` read 0.
- R4: When the stop bit has been sampled, the character appears on `rx_data` and `rx_ready` goes to 1.
- R5: A cycle with `rd_en`=1 and no character completing clears `rx_ready` and `ovr_err`.
- R6: When `par_en`=1, one parity bit follows the data. With `par_odd`=0 the expected bit is the XOR of the data bits, and with `par_odd`=1 it is the inverse. A mismatch sets `par_err` for that character. When `par_en`=0, `par_err` is 0.
- R7: `frm_err` is 1 for a character whose stop bit is sampled low and 0 otherwise. Status flags change only when a character completes.
- R8: If the start bit, every data bit, the parity bit (if enabled) and the stop bit are all low, `brk_det` is set. It clears once the synchronized line is seen high. A line held low yields only one character.
- R9: If a character completes while `rx_ready` is 1 and `rd_en` is 0, `ovr_err` is set and the new character overwrites `rx_data`.
- R10: `div_sel` 00 selects 1 tick per bit with no mid-bit re-check: each bit is sampled once on a tick. 01 selects 16 ticks per bit, and 10 or 11 select 64 ticks per bit.
- R11: If `rd_en` is 1 in the same cycle that a character completes, the new character is kept with `rx_ready`=1, and `ovr_err` is cleared rather than set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_tick | input | 1 | Receive clock enable, one pulse per oversample tick |
| rxd | input | 1 | Serial data input, idle high |
| div_sel | input | 2 | Ticks per bit: 00=1, 01=16, 1x=64 |
| len_sel | input | 2 | Data bits minus 5 |
| par_en | input | 1 | Parity bit present |
| par_odd | input | 1 | 1 = odd parity, 0 = even |
| rd_en | input | 1 | One-cycle read strobe for the buffer register |
| rx_data | output | 8 | Buffered character, right-justified |
| rx_ready | output | 1 | Buffer holds an unread character |
| par_err | output | 1 | Parity mismatch on the buffered character |
| frm_err | output | 1 | Stop bit sampled low |
| ovr_err | output | 1 | A character was overwritten before being read |
| brk_det | output | 1 | All-low frame seen, line not yet high again |

## Verification
Character completion and a host read can fall in the same clock cycle. That collision decides between overrun and a clean handover. The bench provokes it in 1x mode: a first character is left unread, then the read strobe is placed exactly on the cycle in which the second stop bit is taken into the buffer. It judges that `rx_ready` stays 1 with the second character on `rx_data` and `ovr_err` at 0. In the random frames, unread characters are stacked so that the ordinary overrun path is also exercised.

// File: rtl/async_rx_pkg.sv
package async_rx_pkg;

  localparam int CHAR_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP,
    ST_HOLD
  } rx_state_t;

  typedef struct packed {
    logic [CHAR_W-1:0] data;
    logic              par_err;
    logic              frm_err;
    logic              brk;
  } rx_char_t;

  // index of the last data bit for a length code (5..8 bits)
  function automatic logic [2:0] last_bit_idx(input logic [1:0] len_code);
    return {1'b1, len_code};
  endfunction

endpackage

// File: rtl/rx_line_sync.sv
module rx_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic line_in,
  output logic line_s
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain[0] <= 1'b1;
    else     chain[0] <= line_in;
  end

  generate
    for (genvar g = 1; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) chain[g] <= 1'b1;
        else     chain[g] <= chain[g-1];
      end
    end
  endgenerate

  assign line_s = chain[STAGES-1];
endmodule

// File: rtl/rx_bit_timer.sv
module rx_bit_timer #(
  parameter int DIV_MID = 16,
  parameter int DIV_HI  = 64
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       restart,
  input  logic [1:0] div_sel,
  output logic       mid_hit,
  output logic       bit_hit
);
  localparam int CNT_W = $clog2(DIV_HI);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] full_m1;
  logic [CNT_W-1:0] half_m1;

  always_comb begin
    unique case (div_sel)
      2'b00:   begin full_m1 = '0;                 half_m1 = '0; end
      2'b01:   begin full_m1 = CNT_W'(DIV_MID - 1); half_m1 = CNT_W'(DIV_MID/2 - 1); end
      default: begin full_m1 = CNT_W'(DIV_HI - 1);  half_m1 = CNT_W'(DIV_HI/2 - 1); end
    endcase
  end

  assign mid_hit = tick && (cnt == half_m1);
  assign bit_hit = tick && (cnt == full_m1);

  always_ff @(posedge clk) begin
    if (rst)          cnt <= '0;
    else if (restart) cnt <= '0;
    else if (tick)    cnt <= bit_hit ? '0 : cnt + 1'b1;
  end
endmodule

// File: rtl/rx_frame_fsm.sv
module rx_frame_fsm
  import async_rx_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       line_s,
  input  logic       x1_mode,
  input  logic [1:0] len_sel,
  input  logic       par_en,
  input  logic       par_odd,
  input  logic       mid_hit,
  input  logic       bit_hit,
  output logic       timer_restart,
  output logic       done,
  output rx_char_t   char_out
);
  rx_state_t         state;
  logic [CHAR_W-1:0] shreg;
  logic [2:0]        idx;
  logic              par_bit;
  logic              all_low;
  logic [2:0]        last_idx;

  assign last_idx = last_bit_idx(len_sel);

  assign timer_restart = tick &&
    (((state == ST_IDLE) && !line_s) || ((state == ST_START) && mid_hit));

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      shreg    <= '0;
      idx      <= '0;
      par_bit  <= 1'b0;
      all_low  <= 1'b1;
      done     <= 1'b0;
      char_out <= '0;
    end else begin
      done <= 1'b0;
      if (tick) begin
        unique case (state)
          ST_IDLE: begin
            if (!line_s) begin
              state   <= x1_mode ? ST_DATA : ST_START;
              shreg   <= '0;
              idx     <= '0;
              all_low <= 1'b1;
            end
          end
          ST_START: begin
            if (mid_hit) state <= line_s ? ST_IDLE : ST_DATA;
          end
          ST_DATA: begin
            if (bit_hit) begin
              shreg[idx] <= line_s;
              all_low    <= all_low & ~line_s;
              idx        <= idx + 1'b1;
              if (idx == last_idx) state <= par_en ? ST_PAR : ST_STOP;
            end
          end
          ST_PAR: begin
            if (bit_hit) begin
              par_bit <= line_s;
              all_low <= all_low & ~line_s;
              state   <= ST_STOP;
            end
          end
          ST_STOP: begin
            if (bit_hit) begin
              done             <= 1'b1;
              char_out.data    <= shreg;
              char_out.par_err <= par_en && (par_bit != ((^shreg) ^ par_odd));
              char_out.frm_err <= ~line_s;
              char_out.brk     <= ~line_s & all_low;
              state            <= line_s ? ST_IDLE : ST_HOLD;
            end
          end
          ST_HOLD: begin
            if (line_s) state <= ST_IDLE;
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/rx_char_buffer.sv
module rx_char_buffer
  import async_rx_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              done,
  input  rx_char_t          char_in,
  input  logic              rd_en,
  input  logic              line_s,
  output logic [CHAR_W-1:0] rx_data,
  output logic              rx_ready,
  output logic              par_err,
  output logic              frm_err,
  output logic              ovr_err,
  output logic              brk_det
);
  always_ff @(posedge clk) begin
    if (rst) begin
      rx_data  <= '0;
      rx_ready <= 1'b0;
      par_err  <= 1'b0;
      frm_err  <= 1'b0;
      ovr_err  <= 1'b0;
      brk_det  <= 1'b0;
    end else if (done) begin
      rx_data  <= char_in.data;
      rx_ready <= 1'b1;
      par_err  <= char_in.par_err;
      frm_err  <= char_in.frm_err;
      ovr_err  <= (rx_ready | ovr_err) & ~rd_en;
      brk_det  <= char_in.brk;
    end else begin
      if (rd_en) begin
        rx_ready <= 1'b0;
        ovr_err  <= 1'b0;
      end
      if (line_s) brk_det <= 1'b0;
    end
  end
endmodule

// File: rtl/async_rx_core.sv
module async_rx_core
  import async_rx_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int DIV_MID     = 16,
  parameter int DIV_HI      = 64
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       rx_tick,
  input  logic       rxd,
  input  logic [1:0] div_sel,
  input  logic [1:0] len_sel,
  input  logic       par_en,
  input  logic       par_odd,
  input  logic       rd_en,
  output logic [7:0] rx_data,
  output logic       rx_ready,
  output logic       par_err,
  output logic       frm_err,
  output logic       ovr_err,
  output logic       brk_det
);
  logic     line_s;
  logic     mid_hit;
  logic     bit_hit;
  logic     timer_restart;
  logic     frame_done;
  rx_char_t frame_char;

  rx_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .line_in (rxd),
    .line_s  (line_s)
  );

  rx_bit_timer #(.DIV_MID(DIV_MID), .DIV_HI(DIV_HI)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .tick    (rx_tick),
    .restart (timer_restart),
    .div_sel (div_sel),
    .mid_hit (mid_hit),
    .bit_hit (bit_hit)
  );

  rx_frame_fsm u_fsm (
    .clk           (clk),
    .rst           (rst),
    .tick          (rx_tick),
    .line_s        (line_s),
    .x1_mode       (div_sel == 2'b00),
    .len_sel       (len_sel),
    .par_en        (par_en),
    .par_odd       (par_odd),
    .mid_hit       (mid_hit),
    .bit_hit       (bit_hit),
    .timer_restart (timer_restart),
    .done          (frame_done),
    .char_out      (frame_char)
  );

  rx_char_buffer u_buf (
    .clk      (clk),
    .rst      (rst),
    .done     (frame_done),
    .char_in  (frame_char),
    .rd_en    (rd_en),
    .line_s   (line_s),
    .rx_data  (rx_data),
    .rx_ready (rx_ready),
    .par_err  (par_err),
    .frm_err  (frm_err),
    .ovr_err  (ovr_err),
    .brk_det  (brk_det)
  );
endmodule

// File: rtl/async_rx_chk.sv
module async_rx_chk (
  input logic clk,
  input logic rst,
  input logic rd_en,
  input logic frame_done,
  input logic line_s,
  input logic rx_ready,
  input logic par_err,
  input logic frm_err,
  input logic ovr_err,
  input logic brk_det
);
  logic rst_q = 1'b0;
  always_ff @(posedge clk) rst_q <= rst;

  always_ff @(posedge clk) begin
    if (rst_q && !rst) begin
      a_r1_reset_clear: assert (!rx_ready && !ovr_err && !brk_det && !frm_err && !par_err)
        else $error("R1 flags not clear after reset");
    end
  end

  a_r4_done_sets_ready: assert property (@(posedge clk) disable iff (rst)
    frame_done |=> rx_ready);

  a_r5_read_clears: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !frame_done) |=> (!rx_ready && !ovr_err));

  a_r9_overrun_set: assert property (@(posedge clk) disable iff (rst)
    (frame_done && rx_ready && !rd_en) |=> ovr_err);

  a_r11_read_at_done: assert property (@(posedge clk) disable iff (rst)
    (frame_done && rd_en) |=> (rx_ready && !ovr_err));

  a_r8_break_clears: assert property (@(posedge clk) disable iff (rst)
    (line_s && !frame_done) |=> !brk_det);

  a_r7_flags_hold: assert property (@(posedge clk) disable iff (rst)
    !frame_done |=> ($stable(frm_err) && $stable(par_err)));
endmodule

bind async_rx_core async_rx_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .rd_en      (rd_en),
  .frame_done (frame_done),
  .line_s     (line_s),
  .rx_ready   (rx_ready),
  .par_err    (par_err),
  .frm_err    (frm_err),
  .ovr_err    (ovr_err),
  .brk_det    (brk_det)
);

// File: tb/async_rx_core_tb_top.sv
`timescale 1ns/1ps
module async_rx_core_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rx_tick = 1'b1;
  logic       rxd = 1'b1;
  logic [1:0] div_sel = 2'b01;
  logic [1:0] len_sel = 2'b11;
  logic       par_en = 1'b0;
  logic       par_odd = 1'b0;
  logic       rd_en = 1'b0;
  logic [7:0] rx_data;
  logic       rx_ready, par_err, frm_err, ovr_err, brk_det;

  int n_checks = 0;
  int n_fail   = 0;
  bit pending  = 0;
  bit exp_ovr  = 0;

  always #4 clk = ~clk;

  async_rx_core dut_i (
    .clk(clk), .rst(rst), .rx_tick(rx_tick), .rxd(rxd), .div_sel(div_sel),
    .len_sel(len_sel), .par_en(par_en), .par_odd(par_odd), .rd_en(rd_en),
    .rx_data(rx_data), .rx_ready(rx_ready), .par_err(par_err),
    .frm_err(frm_err), .ovr_err(ovr_err), .brk_det(brk_det)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic int ticks_per_bit(input logic [1:0] d);
    return (d == 2'b00) ? 1 : (d == 2'b01) ? 16 : 64;
  endfunction

  function automatic logic [7:0] mask_len(input logic [7:0] d, input logic [1:0] l);
    return d & ((8'd1 << (5 + l)) - 8'd1);
  endfunction

  function automatic logic parity_of(input logic [7:0] d, input logic odd);
    return (^d) ^ odd;
  endfunction

  task automatic hold_bit(input logic v, input int n);
    rxd = v;
    repeat (n) @(negedge clk);
  endtask

  // drives one frame (without trailing idle)
  task automatic drive_frame(input logic [7:0] d, input logic flip_par, input logic stop_v);
    int tb = ticks_per_bit(div_sel);
    int nb = 5 + len_sel;
    hold_bit(1'b0, tb);
    for (int i = 0; i < nb; i++) hold_bit(d[i], tb);
    if (par_en) hold_bit(parity_of(d, par_odd) ^ flip_par, tb);
    hold_bit(stop_v, tb);
  endtask

  task automatic do_read();
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    @(negedge clk);
    chk("R5 ready after read", rx_ready, 0);
    chk("R5 overrun after read", ovr_err, 0);
    pending = 0;
    exp_ovr = 0;
  endtask

  task automatic frame_and_check(input logic [7:0] d, input logic flip_par, input logic bad_stop);
    logic [7:0] dm = mask_len(d, len_sel);
    drive_frame(dm, flip_par, ~bad_stop);
    hold_bit(1'b1, 5);
    exp_ovr = exp_ovr | pending;
    chk("R3 R4 data", rx_data, dm);
    chk("R4 ready", rx_ready, 1);
    chk("R6 parity error", par_err, par_en & flip_par);
    chk("R7 framing error", frm_err, bad_stop);
    chk("R9 overrun", ovr_err, exp_ovr);
    if (!bad_stop) chk("R8 break idle", brk_det, 0);
    pending = 1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL R4 watchdog act=running exp=finished");
    $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    int seed = $urandom(32'h51A7);
    seed = seed + 1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1
    chk("R1 ready", rx_ready, 0);
    chk("R1 data", rx_data, 0);
    chk("R1 flags", {par_err, frm_err, ovr_err, brk_det}, 0);

    // R2: false starts at 16x and 64x, then a valid frame
    div_sel = 2'b01; len_sel = 2'b11; par_en = 0;
    hold_bit(1'b0, 5); hold_bit(1'b1, 40);
    chk("R2 false start 16x", rx_ready, 0);
    div_sel = 2'b10;
    hold_bit(1'b0, 25); hold_bit(1'b1, 100);
    chk("R2 false start 64x", rx_ready, 0);
    frame_and_check(8'hA5, 0, 0);
    do_read();

    // R10: 11 also means 64x, 5-bit chars in 1x
    div_sel = 2'b11; len_sel = 2'b00; par_en = 1; par_odd = 1;
    frame_and_check(8'hFF, 0, 0);
    do_read();
    div_sel = 2'b00;
    frame_and_check(8'h13, 0, 0);

    // R11: read lands on the completion cycle of a second char (1x)
    len_sel = 2'b11; par_en = 0;
    hold_bit(1'b0, 1);
    for (int i = 0; i < 8; i++) hold_bit(i[0], 1);
    rxd = 1'b1;
    repeat (3) @(negedge clk);
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    repeat (3) @(negedge clk);
    chk("R11 ready kept", rx_ready, 1);
    chk("R11 data", rx_data, 8'hAA);
    chk("R11 no overrun", ovr_err, 0);
    pending = 1; exp_ovr = 0;
    do_read();

    // R8: break at 16x
    div_sel = 2'b01; len_sel = 2'b11; par_en = 1; par_odd = 0;
    hold_bit(1'b0, 16 * 14);
    chk("R8 break set", brk_det, 1);
    chk("R8 framing", frm_err, 1);
    chk("R8 data zero", rx_data, 0);
    do_read();
    hold_bit(1'b0, 40);
    chk("R8 single char while low", rx_ready, 0);
    hold_bit(1'b1, 6);
    chk("R8 break clears", brk_det, 0);
    chk("R8 no extra char", rx_ready, 0);

    // random frames
    for (int k = 0; k < 60; k++) begin
      int r = $urandom;
      div_sel = (r[1:0] == 2'b00) ? 2'b00 : (r[1:0] == 2'b11 && r[9]) ? 2'b10 : 2'b01;
      len_sel = r[3:2];
      par_en  = r[4];
      par_odd = r[5];
      frame_and_check(r[23:16], par_en && (r[12:10] == 3'd0), r[15:13] == 3'd0);
      if (r[6]) do_read();
    end

    $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule